// File: doc/BRIEF.md
# Two-Level Serial Interrupt Aggregator

This block gathers interrupt requests for a serial communications controller in two layers. Each functional unit (receive machine, receive FIFO, transmit FIFO, transmit machine, modem, timers) reports one-cycle event pulses. Each pulse sets a sticky status bit that software clears by writing ones. The receive machine, modem and timer units also carry a per-source enable register. A unit's summary request is the OR of its enabled status bits. For the transmit machine and the two FIFO units it is the OR of the raw status bits.

A device-wide enable register then gates each unit summary. The surviving requests go to a fixed-priority resolver. It produces one registered, level-sensitive interrupt output and a 3-bit code naming the winning unit. Software reaches the enables, the status bits and the resolved result through a simple register port. Reads are combinational and writes take effect on a clock edge.

Top module: `serial_irq_hub`

## Requirements
- R1: After reset every enable register and every status bit is zero and `irq` is low. Nothing can raise `irq` until enables are written.
- R2: An event pulse sets its status bit on the next clock edge. The bit then holds until software clears it.
- R3: Writing a status register clears each bit written as 1 and leaves each bit written as 0. When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R4: The receive machine has seven sources, each with its own enable bit at the same position as its status bit: 0 character recognized, 1 programmable match, 2 break end, 3 break start, 4 framing error, 5 parity error, 6 overrun. The modem and timer units likewise pair enable bit i with status bit i. Each unit's summary is the OR of status AND enable.
- R5: The transmit machine and both FIFO units have no per-source enable. Their summary is the OR of their raw status bits.
- R6: The device enable register holds one bit per unit, indexed 0 receive machine, 1 receive FIFO, 2 transmit FIFO, 3 transmit machine, 4 modem, 5 timers. A 1 passes that unit's summary and a 0 masks it.
- R7: Among the units that pass device masking, the lowest index wins, so the receive machine ranks highest and the timers lowest. `irq_code` reports the winner's index.
- R8: `irq` and `irq_code` are registered. `irq` rises on the clock edge after an enabled request appears and falls on the clock edge after the last enabled request disappears.
- R9: Register map, addressed by `reg_addr`:
  - 0: device enable.
  - 1: device status, the ungated unit summaries at the R6 bit indices.
  - 2: resolved result, with the pending flag in bit 3 and the code in bits 2:0.
  - 3: receive status. 4: receive enable.
  - 5: modem status. 6: modem enable.
  - 7: timer status. 8: timer enable.
  - 9: transmit machine status.
  - 10: FIFO status, with bit 0 for the receive FIFO and bit 1 for the transmit FIFO.
  - Other addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Write data (status registers: ones clear) |
| reg_rdata | output | DW | Combinational read data |
| rxm_evt | input | 7 | Receive machine event pulses |
| mdm_evt | input | MDM_N | Modem event pulses |
| tmr_evt | input | TMR_N | Timer event pulses |
| txm_evt | input | TXM_N | Transmit machine event pulses |
| rxf_evt | input | 1 | Receive FIFO event pulse |
| txf_evt | input | 1 | Transmit FIFO event pulse |
| irq | output | 1 | Registered level interrupt request |
| irq_code | output | 3 | Index of the winning unit |

## Verification
The bench raises a receive error while its source enable is zero and confirms that neither the device status nor `irq` moves. A design that ignored the unit-level enable would interrupt at once. It then issues a clear and an event to the same bit in one cycle; a design where the clear won would drop a real event. It stacks requests from several units and removes them one at a time, watching the code step down the priority order. It also checks that `irq` rises and falls exactly one edge after the cause, which catches both combinational and doubly registered outputs. Finally it runs raw-status units with no unit enables set, which catches a design that wrongly masks them.

// File: rtl/serial_irq_hub.sv
module serial_irq_hub #(
  parameter int DW    = 8,
  parameter int AW    = 4,
  parameter int MDM_N = 4,
  parameter int TMR_N = 2,
  parameter int TXM_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [6:0]       rxm_evt,
  input  logic [MDM_N-1:0] mdm_evt,
  input  logic [TMR_N-1:0] tmr_evt,
  input  logic [TXM_N-1:0] txm_evt,
  input  logic             rxf_evt,
  input  logic             txf_evt,
  output logic             irq,
  output logic [2:0]       irq_code
);
  localparam int NU = 6;
  localparam logic [AW-1:0] A_DEN = AW'(0), A_DST = AW'(1), A_GIR = AW'(2),
                            A_RXS = AW'(3), A_RXE = AW'(4), A_MDS = AW'(5),
                            A_MDE = AW'(6), A_TMS = AW'(7), A_TME = AW'(8),
                            A_TXS = AW'(9), A_FFS = AW'(10);

  logic [NU-1:0]    dev_en, summ, gated;
  logic [6:0]       rxm_st, rxm_en;
  logic [MDM_N-1:0] mdm_st, mdm_en;
  logic [TMR_N-1:0] tmr_st, tmr_en;
  logic [TXM_N-1:0] txm_st;
  logic [1:0]       fifo_st;
  logic [2:0]       win;
  logic             irq_q;
  logic [2:0]       code_q;

  function automatic logic hit(input logic [AW-1:0] a);
    return reg_wr && (reg_addr == a);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_en <= '0;
      rxm_en <= '0;
      mdm_en <= '0;
      tmr_en <= '0;
    end else begin
      if (hit(A_DEN)) dev_en <= reg_wdata[NU-1:0];
      if (hit(A_RXE)) rxm_en <= reg_wdata[6:0];
      if (hit(A_MDE)) mdm_en <= reg_wdata[MDM_N-1:0];
      if (hit(A_TME)) tmr_en <= reg_wdata[TMR_N-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxm_st  <= '0;
      mdm_st  <= '0;
      tmr_st  <= '0;
      txm_st  <= '0;
      fifo_st <= '0;
    end else begin
      rxm_st  <= (rxm_st  & ~(hit(A_RXS) ? reg_wdata[6:0]       : '0)) | rxm_evt;
      mdm_st  <= (mdm_st  & ~(hit(A_MDS) ? reg_wdata[MDM_N-1:0] : '0)) | mdm_evt;
      tmr_st  <= (tmr_st  & ~(hit(A_TMS) ? reg_wdata[TMR_N-1:0] : '0)) | tmr_evt;
      txm_st  <= (txm_st  & ~(hit(A_TXS) ? reg_wdata[TXM_N-1:0] : '0)) | txm_evt;
      fifo_st <= (fifo_st & ~(hit(A_FFS) ? reg_wdata[1:0]       : '0)) | {txf_evt, rxf_evt};
    end
  end

  assign summ  = {|(tmr_st & tmr_en), |(mdm_st & mdm_en), |txm_st,
                  fifo_st[1], fifo_st[0], |(rxm_st & rxm_en)};
  assign gated = summ & dev_en;

  always_comb begin
    win = '0;
    for (int i = NU - 1; i >= 0; i--)
      if (gated[i]) win = 3'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      code_q <= '0;
    end else begin
      irq_q  <= |gated;
      code_q <= win;
    end
  end

  assign irq      = irq_q;
  assign irq_code = code_q;

  always_comb begin
    case (reg_addr)
      A_DEN:   reg_rdata = DW'(dev_en);
      A_DST:   reg_rdata = DW'(summ);
      A_GIR:   reg_rdata = DW'({irq_q, code_q});
      A_RXS:   reg_rdata = DW'(rxm_st);
      A_RXE:   reg_rdata = DW'(rxm_en);
      A_MDS:   reg_rdata = DW'(mdm_st);
      A_MDE:   reg_rdata = DW'(mdm_en);
      A_TMS:   reg_rdata = DW'(tmr_st);
      A_TME:   reg_rdata = DW'(tmr_en);
      A_TXS:   reg_rdata = DW'(txm_st);
      A_FFS:   reg_rdata = DW'(fifo_st);
      default: reg_rdata = '0;
    endcase
  end

  p_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_en == '0) |=> !irq);

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rxm_evt[0] |=> rxm_st[0]);

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit(A_RXS) && reg_wdata[0] && !rxm_evt[0]) |=> !rxm_st[0]);

  p_top_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_en[0] && |(rxm_st & rxm_en)) |=> (irq && irq_code == 3'd0));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (summ == '0) |=> !irq);
endmodule

// File: tb/test_serial_irq_hub.sv
module test_serial_irq_hub;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [6:0] rxm_evt = '0;
  logic [3:0] mdm_evt = '0;
  logic [1:0] tmr_evt = '0, txm_evt = '0;
  logic       rxf_evt = 1'b0, txf_evt = 1'b0, irq;
  logic [2:0] irq_code;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  serial_irq_hub i_serial_irq_hub (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxm_evt(rxm_evt),
    .mdm_evt(mdm_evt), .tmr_evt(tmr_evt), .txm_evt(txm_evt),
    .rxf_evt(rxf_evt), .txf_evt(txf_evt), .irq(irq), .irq_code(irq_code));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_addr = 4'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = 4'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    int d;
    chk("R1 irq", int'(irq), 0);
    rd(0, d); chk("R1 dev_en", d, 0);
    rd(4, d); chk("R1 rx_en", d, 0);
    rd(3, d); chk("R1 rx_st", d, 0);
  endtask

  task automatic t_sticky_masked();
    int d;
    rxm_evt = 7'h10; @(negedge clk); rxm_evt = '0;
    settle();
    rd(3, d); chk("R2 rx_st held", d, 'h10);
    rd(1, d); chk("R4 summary masked", d & 1, 0);
    chk("R1 irq masked", int'(irq), 0);
  endtask

  task automatic t_enable_timing();
    int d;
    wr(4, 'h10);
    rd(1, d); chk("R4 summary enabled", d & 1, 1);
    chk("R6 dev mask", int'(irq), 0);
    wr(0, 'h3F);
    chk("R8 not yet", int'(irq), 0);
    @(negedge clk);
    chk("R8 rise", int'(irq), 1);
    chk("R7 code rx", int'(irq_code), 0);
  endtask

  task automatic t_clear();
    int d;
    wr(3, 'h00);
    rd(3, d); chk("R3 zero write keeps", d, 'h10);
    reg_addr = 4'd3; reg_wdata = 8'h10; reg_wr = 1'b1; rxm_evt = 7'h10;
    @(negedge clk); reg_wr = 1'b0; rxm_evt = '0;
    rd(3, d); chk("R3 set wins", d, 'h10);
    wr(3, 'h10);
    rd(3, d); chk("R3 cleared", d, 0);
    chk("R8 fall delayed", int'(irq), 1);
    @(negedge clk);
    chk("R8 fall", int'(irq), 0);
  endtask

  task automatic t_raw_and_prio();
    int d;
    txf_evt = 1'b1; @(negedge clk); txf_evt = 1'b0;
    settle();
    rd(1, d); chk("R5 txf raw", d, 'h04);
    chk("R7 code txf", int'(irq_code), 2);
    txm_evt = 2'b10; mdm_evt = 4'h1; @(negedge clk); txm_evt = '0; mdm_evt = '0;
    settle();
    rd(1, d); chk("R5 txm raw, R4 mdm masked", d, 'h0C);
    chk("R7 txf over txm", int'(irq_code), 2);
    rxf_evt = 1'b1; @(negedge clk); rxf_evt = 1'b0;
    settle();
    chk("R7 code rxf", int'(irq_code), 1);
    wr(10, 'h3);
    settle();
    chk("R7 code txm", int'(irq_code), 3);
    wr(0, 'h37);
    settle();
    chk("R6 masked txm", int'(irq), 0);
  endtask

  task automatic t_timer();
    int d;
    wr(8, 'h1); wr(0, 'h3F);
    tmr_evt = 2'b01; @(negedge clk); tmr_evt = '0;
    settle();
    chk("R7 txm over tmr", int'(irq_code), 3);
    wr(9, 'h3);
    settle();
    chk("R7 code tmr", int'(irq_code), 5);
    rd(2, d); chk("R9 result reg", d, 'h0D);
    rd(11, d); chk("R9 unmapped", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky_masked();
    t_enable_timing();
    t_clear();
    t_raw_and_prio();
    t_timer();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule